// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the synchronous shift mode of a simple serial port. It moves one byte at a time over two pins. A bidirectional data pin carries the bits in both directions. A second pin only ever outputs the shift clock. The port works half duplex, so only one transfer runs at a time. The bit rate is the core clock divided by a fixed ratio, 12 by default. The data pin has its own output-enable and is driven only during a transmit.

A transmit starts when the host writes the data buffer. A receive is armed by state rather than by a start bit: it begins as soon as receive is enabled and the receive-complete flag is clear. The host clears the two completion flags through dedicated clear strobes. The received byte stays readable on the buffer read port until the next receive completes.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data output-enable is 0, both completion flags are 0 and the read buffer is 0.
- R2: While mode select is 2'b00 and no transfer runs, a buffer write starts a transmit. The written byte is driven on the data pin least significant bit first, each bit for 12 core cycles, with the output-enable high throughout. A write in the same cycle as an armed receive wins and starts a transmit.
- R3: During a transfer each bit period is 6 cycles with the clock low followed by 6 cycles with it high. Data changes on the falling edge, so there are exactly eight clock pulses. Outside a transfer the clock stays high.
- R4: A transmit ends 96 cycles after its start edge. The transmit-done flag then reads 1, the output-enable returns to 0 and the clock is high.
- R5: While mode select is 2'b00 and no transfer runs, receive-enable 1 with the receive flag 0 starts a receive. The data pin is sampled at each rising clock edge and assembled least significant bit first. 96 cycles after the start edge the byte appears on the read port and the receive flag reads 1. The output-enable stays 0 for the whole receive.
- R6: While the receive flag is 1, receive-enable starts no transfer: the clock stays high.
- R7: With mode select other than 2'b00, buffer writes and receive-enable start nothing.
- R8: A buffer write during a running transfer is ignored, and the bits already in progress continue unchanged.
- R9: Each clear strobe zeroes its own flag on the next edge. When a flag's clear and its set fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Serial mode select; 2'b00 enables this mode |
| rx_en | input | 1 | Receive enable |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_full | input | 1 | Clears the receive flag |
| data_i | input | 1 | Data pin input path |
| buf_rdata | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit-done flag |
| rx_full | output | 1 | Receive-complete flag |
| sclk_o | output | 1 | Shift clock pin |
| data_o | output | 1 | Data pin output path |
| data_oe | output | 1 | Data pin output-enable |

## Verification
The bench counts cycles from the edge that takes a write or a receive arm. After that edge the clock goes low at once. Bit i is driven from cycle 12*i. The rising clock edge, where receive data is sampled, falls at cycle 12*i+6. The flags, the read byte and the idle pin state are due at cycle 96. The bench drives stimulus on falling core-clock edges and checks every cycle of a transfer at the following falling edge against positions worked out from those counts. A clear or an ignored stimulus is checked one edge after it is applied, and kept under watch for several dozen cycles.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DIV = 12,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          rx_en,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          clr_tx_done,
  input  logic          clr_rx_full,
  input  logic          data_i,
  output logic [DW-1:0] buf_rdata,
  output logic          tx_done,
  output logic          rx_full,
  output logic          sclk_o,
  output logic          data_o,
  output logic          data_oe
);
  localparam int HALF = DIV / 2;
  localparam int PW   = $clog2(DIV);
  localparam int BW   = (DW > 2) ? $clog2(DW) : 1;

  logic          busy, is_tx;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;

  wire sel      = (mode_sel == 2'b00);
  wire start_tx = sel && !busy && buf_wr;
  wire start_rx = sel && !busy && !buf_wr && rx_en && !rx_full;
  wire rise     = busy && (ph == PW'(HALF - 1));
  wire bit_end  = busy && (ph == PW'(DIV - 1));
  wire last     = bit_end && (bitn == BW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      is_tx <= 1'b0;
      ph    <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (start_tx || start_rx) begin
      busy  <= 1'b1;
      is_tx <= start_tx;
      ph    <= '0;
      bitn  <= '0;
      shreg <= start_tx ? buf_wdata : '0;
    end else if (busy) begin
      ph <= bit_end ? '0 : ph + 1'b1;
      if (rise && !is_tx) shreg <= {data_i, shreg[DW-1:1]};
      if (bit_end) begin
        bitn <= bitn + 1'b1;
        if (is_tx) shreg <= {1'b0, shreg[DW-1:1]};
        if (last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_rdata <= '0;
      tx_done   <= 1'b0;
      rx_full   <= 1'b0;
    end else begin
      if (last && !is_tx) buf_rdata <= shreg;
      if (last && is_tx) tx_done <= 1'b1;
      else if (clr_tx_done) tx_done <= 1'b0;
      if (last && !is_tx) rx_full <= 1'b1;
      else if (clr_rx_full) rx_full <= 1'b0;
    end
  end

  assign sclk_o  = !busy || (ph >= PW'(HALF));
  assign data_o  = shreg[0];
  assign data_oe = busy && is_tx;
endmodule

module sync_shift_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       buf_wr,
  input logic       rx_en,
  input logic       rx_full,
  input logic       tx_done,
  input logic       sclk_o,
  input logic       data_oe,
  input logic       busy
);
  // R3
  clk_low_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_o |-> busy);
  // R4
  done_drops_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !data_oe && $past(data_oe));
  // R6
  full_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_full && !buf_wr) |=> !busy);
  // R7
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_sel != 2'b00) |=> !busy);
  // R2
  tx_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && data_oe) |-> $past(buf_wr));
  // R5
  rx_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !data_oe) |-> $past(rx_en) && !$past(rx_full));
endmodule

bind sync_shift_port sync_shift_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .buf_wr(buf_wr), .rx_en(rx_en),
  .rx_full(rx_full), .tx_done(tx_done), .sclk_o(sclk_o), .data_oe(data_oe), .busy(busy)
);

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       rx_en = 1'b0, buf_wr = 1'b0, clr_tx_done = 1'b0, clr_rx_full = 1'b0, data_i = 1'b0;
  logic [7:0] buf_wdata = 8'h00;
  logic [7:0] buf_rdata;
  logic       tx_done, rx_full, sclk_o, data_o, data_oe;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sync_shift_port i_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx_en(rx_en), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .clr_tx_done(clr_tx_done), .clr_rx_full(clr_rx_full),
    .data_i(data_i), .buf_rdata(buf_rdata), .tx_done(tx_done), .rx_full(rx_full),
    .sclk_o(sclk_o), .data_o(data_o), .data_oe(data_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_clk(input int c);
    return (c % 12) >= 6;
  endfunction

  function automatic bit exp_bit(input logic [7:0] b, input int c);
    return b[c / 12];
  endfunction

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic xfer(input bit tx, input logic [7:0] b, input bit poke_busy);
    @(negedge clk);
    if (tx) begin buf_wr = 1'b1; buf_wdata = b; end
    else rx_en = 1'b1;
    for (int c = 0; c < 96; c++) begin
      @(negedge clk);
      buf_wr = 1'b0;
      rx_en  = 1'b0;
      if (poke_busy && c == 30) begin buf_wr = 1'b1; buf_wdata = ~b; end
      chk(sclk_o == exp_clk(c), "R3 clock phase", sclk_o, exp_clk(c));
      chk(data_oe == tx, tx ? "R2 oe during tx" : "R5 oe during rx", data_oe, tx);
      if (tx) chk(data_o == exp_bit(b, c), poke_busy ? "R8 stream kept" : "R2 tx bit", data_o, exp_bit(b, c));
      else data_i = exp_bit(b, c);
    end
    @(negedge clk);
    chk(sclk_o == 1'b1 && data_oe == 1'b0, "R4 idle after transfer", {sclk_o, data_oe}, 2'b10);
    if (tx) chk(tx_done == 1'b1, "R4 tx_done set", tx_done, 1);
    else begin
      chk(rx_full == 1'b1, "R5 rx_full set", rx_full, 1);
      chk(buf_rdata == b, "R5 received byte", buf_rdata, b);
    end
  endtask

  task automatic clear_flags;
    @(negedge clk);
    clr_tx_done = 1'b1; clr_rx_full = 1'b1;
    @(negedge clk);
    clr_tx_done = 1'b0; clr_rx_full = 1'b0;
    chk(tx_done == 1'b0 && rx_full == 1'b0, "R9 flags cleared", {tx_done, rx_full}, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    #20 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(sclk_o == 1 && data_oe == 0 && tx_done == 0 && rx_full == 0 && buf_rdata == 0,
        "R1 reset state", {sclk_o, data_oe, tx_done, rx_full, buf_rdata}, 12'h800);

    xfer(1'b1, 8'hA5, 1'b0);
    xfer(1'b0, 8'h3C, 1'b0);
    clear_flags();
    xfer(1'b1, 8'h01, 1'b1);   // R8
    xfer(1'b0, 8'h80, 1'b0);

    // R6: rx_full still 1, arm must not start
    @(negedge clk); rx_en = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      chk(sclk_o == 1'b1, "R6 no rx while full", sclk_o, 1);
    end
    rx_en = 1'b0;
    clear_flags();

    // R7: other mode ignores write and arm
    mode_sel = 2'b01;
    @(negedge clk); buf_wr = 1'b1; buf_wdata = 8'hFF; rx_en = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      buf_wr = 1'b0;
      chk(sclk_o == 1'b1 && data_oe == 1'b0, "R7 mode gate", {sclk_o, data_oe}, 2'b10);
    end
    rx_en = 1'b0;
    @(negedge clk);
    chk(tx_done == 0 && rx_full == 0, "R7 no flags", {tx_done, rx_full}, 0);
    mode_sel = 2'b00;

    // R2 priority: write and arm together give a transmit
    @(negedge clk); rx_en = 1'b1; buf_wr = 1'b1; buf_wdata = 8'h6E;
    @(negedge clk); rx_en = 1'b0; buf_wr = 1'b0;
    chk(data_oe == 1'b1 && data_o == 1'b0, "R2 write wins over arm", {data_oe, data_o}, 2'b10);
    clr_tx_done = 1'b1;   // R9 set wins over held clear
    for (int c = 1; c < 96; c++) @(negedge clk);
    @(negedge clk);
    chk(tx_done == 1'b1, "R9 set wins", tx_done, 1);
    @(negedge clk);
    clr_tx_done = 1'b0;
    chk(tx_done == 1'b0, "R9 clear after set", tx_done, 0);
    clear_flags();

    for (int i = 0; i < 8; i++) begin
      logic [7:0] b = 8'($urandom);
      bit t = 1'($urandom);
      xfer(t, b, 1'b0);
      clear_flags();
    end
    finish_run();
  end
endmodule